// File: doc/BRIEF.md
# Pipeline hazard and forwarding control

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) resolves register dependencies between the instruction in decode and the older instructions still in flight. It is purely combinational. It compares source register numbers against the destination numbers held in the decode/execute, execute/memory and memory/write-back pipeline registers, together with their register-write and load flags. From those comparisons it produces operand bypass selects, a freeze for the program counter and the fetch/decode register, a bubble for decode/execute, and a squash for fetch/decode.

Branches are compared and resolved in decode, and fetch continues sequentially in the meantime. Because of this the block also bypasses into the decode-stage comparator and stalls it when its operand is not ready yet. An ALU result directly ahead of a branch costs one stall cycle. A load directly ahead of a branch costs two. A taken branch squashes the single wrongly fetched instruction. The register file writes early in the cycle and reads late, so a value in write-back never needs a bypass into decode.

Top module: `hazard_ctl`

## Requirements
- R1: An execute-stage operand select reads 1 (take the execute/memory value) when the execute/memory register writes a nonzero destination equal to that operand's source register.
- R2: When R1 does not apply, the select reads 2 (take the memory/write-back value) if the memory/write-back register writes a nonzero destination equal to the source. Otherwise it reads 0 (register file).
- R3: When both the execute/memory and memory/write-back registers match a source, the execute/memory value wins (select 1).
- R4: Register 0 never produces a bypass, a stall or a hazard, whatever the write flags say.
- R5: A load in decode/execute whose nonzero destination matches either decode source raises stall for that cycle. Once the load has moved on to execute/memory and the consumer is not a branch, stall is low.
- R6: A decode-stage select reads 1 only when execute/memory holds a non-load register write whose nonzero destination matches that decode source. Otherwise it reads 0; write-back values are never bypassed into decode.
- R7: A branch in decode whose source matches the nonzero destination of a register-writing instruction in decode/execute stalls.
- R8: A branch in decode whose source matches the nonzero destination of a load in execute/memory also stalls, so a load directly ahead of a branch costs two stall cycles in total.
- R9: Flush is high exactly when decode holds a taken branch and no stall is raised; a stall suppresses the flush.
- R10: With no matching nonzero destination anywhere, all selects read 0 and stall, bubble and flush are low apart from a taken-branch flush.
- R11: Bubble is high in exactly the cycles where stall is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the bound property checker |
| rst_ni | input | 1 | Active-low reset, disables the properties |
| id_rs1_i | input | REG_W | First source register of the decode instruction |
| id_rs2_i | input | REG_W | Second source register of the decode instruction |
| id_branch_i | input | 1 | Decode instruction is a conditional branch |
| id_taken_i | input | 1 | Decode branch comparator says taken |
| ex_rs1_i | input | REG_W | First source held in decode/execute |
| ex_rs2_i | input | REG_W | Second source held in decode/execute |
| ex_rd_i | input | REG_W | Destination held in decode/execute |
| ex_regwr_i | input | 1 | Decode/execute instruction writes a register |
| ex_memrd_i | input | 1 | Decode/execute instruction is a load |
| mem_rd_i | input | REG_W | Destination held in execute/memory |
| mem_regwr_i | input | 1 | Execute/memory instruction writes a register |
| mem_memrd_i | input | 1 | Execute/memory instruction is a load |
| wb_rd_i | input | REG_W | Destination held in memory/write-back |
| wb_regwr_i | input | 1 | Memory/write-back instruction writes a register |
| ex_fwd_a_o | output | 2 | Execute operand A select: 0 file, 1 exe/mem, 2 mem/wb |
| ex_fwd_b_o | output | 2 | Execute operand B select, same encoding |
| id_fwd_a_o | output | 1 | Decode comparator operand A takes the exe/mem value |
| id_fwd_b_o | output | 1 | Decode comparator operand B takes the exe/mem value |
| stall_o | output | 1 | Hold program counter and fetch/decode |
| bubble_o | output | 1 | Clear all control flags entering decode/execute |
| flush_o | output | 1 | Replace fetch/decode with a no-op |

## Verification
On every cycle the properties check several things. Register 0 never bypasses. Execute/memory wins over write-back. A load-use or load-branch match always stalls. A decode bypass never comes from a load. A taken branch flushes unless stalled, and stall and flush never rise together. The multi-cycle sequences can only be shown by the bench scenarios: the single stall of a load-use pair, the two stalls of a load followed by a branch, and the single stall of an ALU result followed by a branch. Its sweep also covers every combination of four register numbers and all seven flags.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_ex_fwd.sv
module hz_ex_fwd
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rs_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wr_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_wr_i,
  output fwd_sel_e         sel_o
);
  logic nz, mem_hit, wb_hit;

  assign nz      = |rs_i;
  assign mem_hit = mem_wr_i && nz && (rs_i == mem_rd_i);
  assign wb_hit  = wb_wr_i && nz && (rs_i == wb_rd_i);

  // younger stage wins
  always_comb begin
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/hz_id_fwd.sv
module hz_id_fwd #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rs_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wr_i,
  input  logic             mem_ld_i,
  output logic             sel_o
);
  // load data is not ready in exe/mem; write-back handled by split-cycle file
  assign sel_o = mem_wr_i && !mem_ld_i && (|rs_i) && (rs_i == mem_rd_i);
endmodule

// File: rtl/hz_stall.sv
module hz_stall #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_branch_i,
  input  logic             id_taken_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_wr_i,
  input  logic             ex_ld_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wr_i,
  input  logic             mem_ld_i,
  output logic             stall_o,
  output logic             flush_o
);
  logic ex_dep, mem_ld_dep, load_use, br_ex, br_mem;

  assign ex_dep     = ex_wr_i && (|ex_rd_i) &&
                      ((ex_rd_i == id_rs1_i) || (ex_rd_i == id_rs2_i));
  assign mem_ld_dep = mem_wr_i && mem_ld_i && (|mem_rd_i) &&
                      ((mem_rd_i == id_rs1_i) || (mem_rd_i == id_rs2_i));

  assign load_use = ex_dep && ex_ld_i;
  assign br_ex    = id_branch_i && ex_dep;
  assign br_mem   = id_branch_i && mem_ld_dep;

  assign stall_o = load_use || br_ex || br_mem;
  // stall wins; branch re-evaluated once operands are ready
  assign flush_o = id_branch_i && id_taken_i && !stall_o;
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_branch_i,
  input  logic             id_taken_i,
  input  logic [REG_W-1:0] ex_rs1_i,
  input  logic [REG_W-1:0] ex_rs2_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_regwr_i,
  input  logic             ex_memrd_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_regwr_i,
  input  logic             mem_memrd_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_regwr_i,
  output logic [1:0]       ex_fwd_a_o,
  output logic [1:0]       ex_fwd_b_o,
  output logic             id_fwd_a_o,
  output logic             id_fwd_b_o,
  output logic             stall_o,
  output logic             bubble_o,
  output logic             flush_o
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] id_rs [NSRC];
  logic [REG_W-1:0] ex_rs [NSRC];
  fwd_sel_e         ex_sel[NSRC];
  logic             id_sel[NSRC];
  logic             stall;

  assign id_rs[0] = id_rs1_i;
  assign id_rs[1] = id_rs2_i;
  assign ex_rs[0] = ex_rs1_i;
  assign ex_rs[1] = ex_rs2_i;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    hz_ex_fwd #(.REG_W(REG_W)) u_ex_fwd (
      .rs_i    (ex_rs[k]),
      .mem_rd_i(mem_rd_i),
      .mem_wr_i(mem_regwr_i),
      .wb_rd_i (wb_rd_i),
      .wb_wr_i (wb_regwr_i),
      .sel_o   (ex_sel[k])
    );
    hz_id_fwd #(.REG_W(REG_W)) u_id_fwd (
      .rs_i    (id_rs[k]),
      .mem_rd_i(mem_rd_i),
      .mem_wr_i(mem_regwr_i),
      .mem_ld_i(mem_memrd_i),
      .sel_o   (id_sel[k])
    );
  end

  hz_stall #(.REG_W(REG_W)) u_stall (
    .id_rs1_i   (id_rs1_i),
    .id_rs2_i   (id_rs2_i),
    .id_branch_i(id_branch_i),
    .id_taken_i (id_taken_i),
    .ex_rd_i    (ex_rd_i),
    .ex_wr_i    (ex_regwr_i),
    .ex_ld_i    (ex_memrd_i),
    .mem_rd_i   (mem_rd_i),
    .mem_wr_i   (mem_regwr_i),
    .mem_ld_i   (mem_memrd_i),
    .stall_o    (stall),
    .flush_o    (flush_o)
  );

  assign ex_fwd_a_o = ex_sel[0];
  assign ex_fwd_b_o = ex_sel[1];
  assign id_fwd_a_o = id_sel[0];
  assign id_fwd_b_o = id_sel[1];
  assign stall_o    = stall;
  assign bubble_o   = stall;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] id_rs1_i,
  input logic             id_branch_i,
  input logic             id_taken_i,
  input logic [REG_W-1:0] ex_rs1_i,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_regwr_i,
  input logic             ex_memrd_i,
  input logic [REG_W-1:0] mem_rd_i,
  input logic             mem_regwr_i,
  input logic             mem_memrd_i,
  input logic [1:0]       ex_fwd_a_o,
  input logic             id_fwd_a_o,
  input logic             stall_o,
  input logic             flush_o
);
  // R3
  prio_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_regwr_i && (mem_rd_i != '0) && (mem_rd_i == ex_rs1_i)) |-> (ex_fwd_a_o == 2'd1));

  // R4
  zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs1_i == '0) |-> (ex_fwd_a_o == 2'd0));

  // R5
  load_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_regwr_i && ex_memrd_i && (ex_rd_i != '0) && (ex_rd_i == id_rs1_i)) |-> stall_o);

  // R6
  id_fwd_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_fwd_a_o |-> (mem_regwr_i && !mem_memrd_i && (mem_rd_i == id_rs1_i)));

  // R8
  br_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_branch_i && mem_regwr_i && mem_memrd_i && (mem_rd_i != '0) && (mem_rd_i == id_rs1_i))
      |-> stall_o);

  // R9
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_branch_i && id_taken_i && !stall_o) |-> flush_o);

  // R9
  stall_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !flush_o);
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .id_rs1_i   (id_rs1_i),
  .id_branch_i(id_branch_i),
  .id_taken_i (id_taken_i),
  .ex_rs1_i   (ex_rs1_i),
  .ex_rd_i    (ex_rd_i),
  .ex_regwr_i (ex_regwr_i),
  .ex_memrd_i (ex_memrd_i),
  .mem_rd_i   (mem_rd_i),
  .mem_regwr_i(mem_regwr_i),
  .mem_memrd_i(mem_memrd_i),
  .ex_fwd_a_o (ex_fwd_a_o),
  .id_fwd_a_o (id_fwd_a_o),
  .stall_o    (stall_o),
  .flush_o    (flush_o)
);

// File: tb/hazard_ctl_bench.sv
module hazard_ctl_bench;
  localparam int REG_W = 5;
  localparam int WDOG  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [REG_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_br, id_tk, ex_wr, ex_ld, mem_wr, mem_ld, wb_wr;
  logic [1:0] ex_fa, ex_fb;
  logic id_fa, id_fb, stall, bubble, flush;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  hazard_ctl #(.REG_W(REG_W)) u_hazard_ctl (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_branch_i(id_br), .id_taken_i(id_tk),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
    .ex_regwr_i(ex_wr), .ex_memrd_i(ex_ld),
    .mem_rd_i(mem_rd), .mem_regwr_i(mem_wr), .mem_memrd_i(mem_ld),
    .wb_rd_i(wb_rd), .wb_regwr_i(wb_wr),
    .ex_fwd_a_o(ex_fa), .ex_fwd_b_o(ex_fb), .id_fwd_a_o(id_fa), .id_fwd_b_o(id_fb),
    .stall_o(stall), .bubble_o(bubble), .flush_o(flush)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_ex(input int rs);
    if (mem_wr && mem_rd != 0 && int'(mem_rd) == rs) return 1;
    if (wb_wr && wb_rd != 0 && int'(wb_rd) == rs) return 2;
    return 0;
  endfunction

  function automatic int exp_id(input int rs);
    return (mem_wr && !mem_ld && mem_rd != 0 && int'(mem_rd) == rs) ? 1 : 0;
  endfunction

  function automatic int exp_stall();
    bit exd, mld;
    exd = ex_wr && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    mld = mem_wr && mem_ld && mem_rd != 0 && (mem_rd == id_rs1 || mem_rd == id_rs2);
    return int'((exd && ex_ld) || (id_br && (exd || mld)));
  endfunction

  task automatic idle();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {id_br, id_tk, ex_wr, ex_ld, mem_wr, mem_ld, wb_wr} = '0;
  endtask

  task automatic check_all();
    int s;
    s = exp_stall();
    chk("R1 R2 R3 R4 ex_fwd_a", int'(ex_fa), exp_ex(int'(ex_rs1)));
    chk("R1 R2 R3 R4 ex_fwd_b", int'(ex_fb), exp_ex(int'(ex_rs2)));
    chk("R6 R4 id_fwd_a", int'(id_fa), exp_id(int'(id_rs1)));
    chk("R6 R4 id_fwd_b", int'(id_fb), exp_id(int'(id_rs2)));
    chk("R5 R7 R8 R10 stall", int'(stall), s);
    chk("R11 bubble", int'(bubble), s);
    chk("R9 R10 flush", int'(flush), int'(id_br && id_tk && s == 0));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // reset state: idle pipeline
    #1;
    chk("R10 reset stall", int'(stall), 0);
    chk("R10 reset flush", int'(flush), 0);
    chk("R10 reset ex_fwd_a", int'(ex_fa), 0);
    rst_n = 1'b1;

    // load-use: lw r3 then add using r3 -> one stall, then exe fwd from wb
    @(negedge clk); idle();
    ex_rd = 3; ex_wr = 1; ex_ld = 1; id_rs1 = 3; id_rs2 = 1; #1;
    chk("R5 load-use cycle1 stall", int'(stall), 1);
    chk("R11 load-use bubble", int'(bubble), 1);
    @(negedge clk); idle();
    mem_rd = 3; mem_wr = 1; mem_ld = 1; id_rs1 = 3; id_rs2 = 1; #1;
    chk("R5 load-use cycle2 stall", int'(stall), 0);
    chk("R6 no decode fwd of load", int'(id_fa), 0);
    @(negedge clk); idle();
    wb_rd = 3; wb_wr = 1; ex_rs1 = 3; ex_rs2 = 1; #1;
    chk("R2 load value from wb", int'(ex_fa), 2);

    // load then branch: two stalls, then no fwd needed
    @(negedge clk); idle();
    ex_rd = 4; ex_wr = 1; ex_ld = 1; id_br = 1; id_tk = 1; id_rs2 = 4; #1;
    chk("R8 ld-br stall1", int'(stall), 1);
    chk("R9 ld-br no flush", int'(flush), 0);
    @(negedge clk); idle();
    mem_rd = 4; mem_wr = 1; mem_ld = 1; id_br = 1; id_tk = 1; id_rs2 = 4; #1;
    chk("R8 ld-br stall2", int'(stall), 1);
    @(negedge clk); idle();
    wb_rd = 4; wb_wr = 1; id_br = 1; id_tk = 1; id_rs2 = 4; #1;
    chk("R8 ld-br released", int'(stall), 0);
    chk("R6 no decode fwd from wb", int'(id_fb), 0);
    chk("R9 flush after release", int'(flush), 1);

    // ALU then branch: one stall, then decode fwd
    @(negedge clk); idle();
    ex_rd = 5; ex_wr = 1; id_br = 1; id_rs1 = 5; #1;
    chk("R7 alu-br stall", int'(stall), 1);
    @(negedge clk); idle();
    mem_rd = 5; mem_wr = 1; id_br = 1; id_rs1 = 5; #1;
    chk("R7 alu-br released", int'(stall), 0);
    chk("R6 decode fwd alu", int'(id_fa), 1);

    // sweep: reg numbers 0..3 on every field, all seven flags
    for (int v = 0; v < (1 << 17); v++) begin
      @(negedge clk);
      id_rs1 = REG_W'(v[1:0]);
      id_rs2 = REG_W'(v[3:2]);
      ex_rd  = REG_W'(v[5:4]);
      mem_rd = REG_W'(v[7:6]);
      wb_rd  = REG_W'(v[9:8]);
      ex_rs1 = id_rs1;
      ex_rs2 = id_rs2;
      {ex_wr, ex_ld, mem_wr, mem_ld, wb_wr, id_br, id_tk} = v[16:10];
      #1;
      check_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule